// File: doc/BRIEF.md
# Processor Mode System Register Unit

This unit keeps the architectural system state that decides how a 64-bit capable core runs. It holds an extended feature register, the control registers 0, 2, 3, 4 and 8, and eight debug registers. Software reaches every register through a single request port: a space selector, a 4-bit index, a write flag and 64 bits of write data. Read data and the fault result come back one clock after the request.

A current-mode input tells the unit whether the requesting code is in 64-bit mode or in a 32-bit mode (legacy or compatibility). The unit applies the rules for that mode. In 64-bit mode it checks reserved upper bits on writes and keeps the full width. In the 32-bit modes it zero-fills the upper half on writes and truncates reads. It also derives the long-mode-active status from the long-mode enable bit and the paging and physical-address-extension inputs. Illegal accesses are turned into a one-cycle fault code. A faulting request leaves all register state unchanged.

Top module: `sysreg_unit`

## Requirements
- R1: In the feature space (req_space = 0, index 0), bit 0 is the fast system-call enable and bit 8 is the long-mode enable. Both can be written and read back.
- R2: Feature bit 10 and the `lma` output are 1 exactly when the stored long-mode enable, `paging_en` and `pae_en` are all 1. Software writes to bit 10 have no effect.
- R3: A feature write that sets any bit other than 0, 8 or 10 returns fault code 1 (general protection). The whole write is dropped.
- R4: In 64-bit mode, a write to control register 0 or 4 (req_space = 1, index 0 or 4) with any of bits 63:32 set returns fault code 1. The register keeps its old value.
- R5: In 64-bit mode, a control register 3 write with any of bits 51:40 set returns fault code 1 and is dropped. Its other bits are unrestricted, and control register 2 accepts any 64-bit value.
- R6: When `mode64` is 0, writes to control and debug registers store zero in bits 63:32 and raise no upper-bit fault. Reads of those registers return zero in bits 63:32.
- R7: Control register 8 keeps bits 3:0 of the write data and reads back zero above them. Accessing it while `mode64` is 0 returns fault code 2 (undefined opcode).
- R8: The following return fault code 2 with no state change: control indices 1, 5, 6, 7 and 9 to 15; debug indices (req_space = 2) 8 to 15; feature indices other than 0; and req_space = 3.
- R9: In 64-bit mode, a write to debug register 6 or 7 with any of bits 63:32 set returns fault code 1 and is dropped. Debug registers 0 to 5 accept any 64-bit value.
- R10: `fault_code` (0 none, 1 general protection, 2 undefined opcode) and `rd_valid` are valid for exactly the one cycle after a request, and are 0 otherwise. `rd_valid` is 1 only for a read that did not fault.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode64 | input | 1 | 1 when the requester runs in 64-bit mode |
| paging_en | input | 1 | Paging enabled |
| pae_en | input | 1 | Physical address extension enabled |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 write, 0 read |
| req_space | input | 2 | 0 feature, 1 control, 2 debug, 3 reserved |
| req_index | input | 4 | Register index within the space |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid (one cycle after request) |
| rd_data | output | 64 | Read data |
| fault_code | output | 2 | Fault result of the previous request |
| lma | output | 1 | Long mode active |

## Verification
The bench writes values with upper bits set in 64-bit mode and then reads them back in the 32-bit modes. A unit that truncated at write time instead of read time, or that forgot to zero-fill, would return the wrong upper half. Faulting writes are always followed by a read of the same register. A design that updated the register before checking it would show the new value there. The bench also toggles paging and extension enables while the long-mode enable is set, which exposes any write path into the status bit. It covers the mode-dependent undefined index for control register 8 and the boundary bits of the control register 3 reserved range (bits 40 and 51 against 39 and 52).

// File: rtl/sysreg_pkg.sv
package sysreg_pkg;

    typedef enum logic [1:0] {
        SP_FEAT = 2'd0,
        SP_CTRL = 2'd1,
        SP_DBG  = 2'd2,
        SP_RSVD = 2'd3
    } space_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_UD   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_FEAT,
        TGT_CR0,
        TGT_CR2,
        TGT_CR3,
        TGT_CR4,
        TGT_TPR,
        TGT_DBG
    } target_e;

    localparam int FEAT_SYSCALL_BIT = 0;
    localparam int FEAT_LME_BIT     = 8;
    localparam int FEAT_LMA_BIT     = 10;

endpackage

// File: rtl/sysreg_width_adapt.sv
module sysreg_width_adapt #(
    parameter int XLEN = 64
) (
    input  logic            narrow,
    input  logic [XLEN-1:0] din,
    output logic [XLEN-1:0] dout
);
    localparam int HALF = XLEN / 2;

    always_comb begin
        dout = din;
        if (narrow) begin
            dout[XLEN-1:HALF] = '0;
        end
    end
endmodule

// File: rtl/sysreg_access_check.sv
module sysreg_access_check
    import sysreg_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int IDX_W      = 4,
    parameter int DBG_N      = 8,
    parameter int CR3_RSV_LO = 40,
    parameter int CR3_RSV_HI = 51
) (
    input  logic [1:0]       space,
    input  logic [IDX_W-1:0] index,
    input  logic             is_write,
    input  logic             mode64,
    input  logic [XLEN-1:0]  wdata,
    output target_e          target,
    output fault_e           fault
);
    localparam int HALF = XLEN / 2;
    localparam logic [XLEN-1:0] FEAT_KEEP =
        (XLEN'(1) << FEAT_SYSCALL_BIT) | (XLEN'(1) << FEAT_LME_BIT) |
        (XLEN'(1) << FEAT_LMA_BIT);

    logic upper_set;
    logic cr3_rsv_set;
    logic gp;

    assign upper_set   = |wdata[XLEN-1:HALF];
    assign cr3_rsv_set = |wdata[CR3_RSV_HI:CR3_RSV_LO];

    always_comb begin
        target = TGT_NONE;
        unique case (space_e'(space))
            SP_FEAT: if (index == '0) target = TGT_FEAT;
            SP_CTRL: begin
                case (int'(index))
                    0:       target = TGT_CR0;
                    2:       target = TGT_CR2;
                    3:       target = TGT_CR3;
                    4:       target = TGT_CR4;
                    8:       target = mode64 ? TGT_TPR : TGT_NONE;
                    default: target = TGT_NONE;
                endcase
            end
            SP_DBG:  if (int'(index) < DBG_N) target = TGT_DBG;
            default: target = TGT_NONE;
        endcase
    end

    always_comb begin
        gp = 1'b0;
        if (is_write) begin
            case (target)
                TGT_FEAT:         gp = |(wdata & ~FEAT_KEEP);
                TGT_CR0, TGT_CR4: gp = mode64 && upper_set;
                TGT_CR3:          gp = mode64 && cr3_rsv_set;
                TGT_DBG:          gp = mode64 && upper_set &&
                                       (int'(index) == 6 || int'(index) == 7);
                default:          gp = 1'b0;
            endcase
        end
    end

    always_comb begin
        if (target == TGT_NONE)  fault = FLT_UD;
        else if (gp)             fault = FLT_GP;
        else                     fault = FLT_NONE;
    end
endmodule

// File: rtl/sysreg_unit.sv
module sysreg_unit
    import sysreg_pkg::*;
#(
    parameter int XLEN       = 64,
    parameter int IDX_W      = 4,
    parameter int DBG_N      = 8,
    parameter int TPR_W      = 4,
    parameter int CR3_RSV_LO = 40,
    parameter int CR3_RSV_HI = 51
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode64,
    input  logic             paging_en,
    input  logic             pae_en,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [1:0]       req_space,
    input  logic [IDX_W-1:0] req_index,
    input  logic [XLEN-1:0]  req_wdata,
    output logic             rd_valid,
    output logic [XLEN-1:0]  rd_data,
    output logic [1:0]       fault_code,
    output logic             lma
);
    localparam int DR_SEL_W = (DBG_N > 1) ? $clog2(DBG_N) : 1;

    typedef struct packed {
        logic                       sce;
        logic                       lme;
        logic [XLEN-1:0]            cr0;
        logic [XLEN-1:0]            cr2;
        logic [XLEN-1:0]            cr3;
        logic [XLEN-1:0]            cr4;
        logic [TPR_W-1:0]           tpr;
        logic [DBG_N-1:0][XLEN-1:0] dr;
        logic                       rd_valid;
        logic [XLEN-1:0]            rdata;
        fault_e                     fault;
    } state_t;

    state_t st_d, st_q;

    target_e             chk_target;
    fault_e              chk_fault;
    logic [XLEN-1:0]     wr_shaped;
    logic [XLEN-1:0]     rd_raw;
    logic [XLEN-1:0]     rd_shaped;
    logic [DR_SEL_W-1:0] dr_sel;
    logic                lma_now;

    assign dr_sel  = req_index[DR_SEL_W-1:0];
    assign lma_now = st_q.lme & paging_en & pae_en;

    sysreg_access_check #(
        .XLEN(XLEN), .IDX_W(IDX_W), .DBG_N(DBG_N),
        .CR3_RSV_LO(CR3_RSV_LO), .CR3_RSV_HI(CR3_RSV_HI)
    ) check_i (
        .space(req_space), .index(req_index), .is_write(req_write),
        .mode64(mode64), .wdata(req_wdata),
        .target(chk_target), .fault(chk_fault)
    );

    sysreg_width_adapt #(.XLEN(XLEN)) wr_adapt_i (
        .narrow(~mode64), .din(req_wdata), .dout(wr_shaped)
    );

    sysreg_width_adapt #(.XLEN(XLEN)) rd_adapt_i (
        .narrow(~mode64), .din(rd_raw), .dout(rd_shaped)
    );

    always_comb begin
        rd_raw = '0;
        case (chk_target)
            TGT_FEAT: begin
                rd_raw[FEAT_SYSCALL_BIT] = st_q.sce;
                rd_raw[FEAT_LME_BIT]     = st_q.lme;
                rd_raw[FEAT_LMA_BIT]     = lma_now;
            end
            TGT_CR0: rd_raw = st_q.cr0;
            TGT_CR2: rd_raw = st_q.cr2;
            TGT_CR3: rd_raw = st_q.cr3;
            TGT_CR4: rd_raw = st_q.cr4;
            TGT_TPR: rd_raw[TPR_W-1:0] = st_q.tpr;
            TGT_DBG: rd_raw = st_q.dr[dr_sel];
            default: rd_raw = '0;
        endcase
    end

    always_comb begin
        st_d          = st_q;
        st_d.rd_valid = 1'b0;
        st_d.rdata    = '0;
        st_d.fault    = FLT_NONE;
        if (req_valid) begin
            st_d.fault = chk_fault;
            if (chk_fault == FLT_NONE) begin
                if (req_write) begin
                    case (chk_target)
                        TGT_FEAT: begin
                            st_d.sce = req_wdata[FEAT_SYSCALL_BIT];
                            st_d.lme = req_wdata[FEAT_LME_BIT];
                        end
                        TGT_CR0: st_d.cr0 = wr_shaped;
                        TGT_CR2: st_d.cr2 = wr_shaped;
                        TGT_CR3: st_d.cr3 = wr_shaped;
                        TGT_CR4: st_d.cr4 = wr_shaped;
                        TGT_TPR: st_d.tpr = req_wdata[TPR_W-1:0];
                        TGT_DBG: st_d.dr[dr_sel] = wr_shaped;
                        default: ;
                    endcase
                end else begin
                    st_d.rd_valid = 1'b1;
                    st_d.rdata    = (chk_target == TGT_FEAT) ? rd_raw : rd_shaped;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_valid   = st_q.rd_valid;
    assign rd_data    = st_q.rdata;
    assign fault_code = st_q.fault;
    assign lma        = lma_now;
endmodule

// File: rtl/sysreg_unit_chk.sv
module sysreg_unit_chk #(
    parameter int XLEN  = 64,
    parameter int IDX_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mode64,
    input logic             paging_en,
    input logic             pae_en,
    input logic             req_valid,
    input logic             req_write,
    input logic [1:0]       req_space,
    input logic [IDX_W-1:0] req_index,
    input logic [XLEN-1:0]  req_wdata,
    input logic             rd_valid,
    input logic [XLEN-1:0]  rd_data,
    input logic [1:0]       fault_code,
    input logic             lma
);
    localparam int HALF = XLEN / 2;

    assert_lma_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lma |-> (paging_en && pae_en));

    assert_upper_gp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && mode64 && req_space == 2'd1 &&
         (req_index == 4'd0 || req_index == 4'd4) && (|req_wdata[XLEN-1:HALF]))
        |=> fault_code == 2'd1);

    assert_narrow_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write && !mode64 && req_space != 2'd0)
        |=> rd_data[XLEN-1:HALF] == '0);

    assert_tpr_legacy_ud_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !mode64 && req_space == 2'd1 && req_index == 4'd8)
        |=> fault_code == 2'd2);

    assert_dbg_hi_ud_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_space == 2'd2 && req_index[3]) |=> fault_code == 2'd2);

    assert_fault_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (fault_code == 2'd0 && !rd_valid));

    assert_code_legal_R10: assert property (@(posedge clk) disable iff (!rst_n)
        fault_code != 2'd3);

    assert_rd_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> fault_code == 2'd0);
endmodule

bind sysreg_unit sysreg_unit_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) chk_i (.*);

// File: tb/sysreg_unit_tb_top.sv
module sysreg_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode64 = 1'b1;
    logic        paging_en = 1'b0;
    logic        pae_en = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [1:0]  req_space = 2'd0;
    logic [3:0]  req_index = 4'd0;
    logic [63:0] req_wdata = 64'd0;
    logic        rd_valid;
    logic [63:0] rd_data;
    logic [1:0]  fault_code;
    logic        lma;

    int n_chk = 0;
    int n_fail = 0;

    logic [63:0] m_ctl [0:15];
    logic [63:0] m_dbg [0:15];
    logic [3:0]  m_tpr = 4'd0;
    logic        m_sce = 1'b0;
    logic        m_lme = 1'b0;

    always #5 clk = ~clk;

    sysreg_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode64(mode64), .paging_en(paging_en),
        .pae_en(pae_en), .req_valid(req_valid), .req_write(req_write),
        .req_space(req_space), .req_index(req_index), .req_wdata(req_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .fault_code(fault_code), .lma(lma)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Per-clock reference comparison of the long-mode-active status (R2)
    always @(posedge clk) begin
        #3;
        if (rst_n) check("R2 lma", {63'd0, lma}, {63'd0, m_lme & paging_en & pae_en});
    end

    task automatic access(input logic [1:0] sp, input int idx, input bit wr,
                          input logic [63:0] wd, input string req);
        logic [1:0]  ef;
        logic [63:0] er;
        bit          m64;
        ef = 2'd0;
        er = 64'd0;
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_space = sp;
        req_index = idx[3:0]; req_wdata = wd;
        m64 = mode64;
        case (sp)
            2'd0: begin
                if (idx != 0) ef = 2'd2;
                else if (wr) begin
                    if ((wd & ~64'h501) != 64'd0) ef = 2'd1;
                end else begin
                    er[0]  = m_sce;
                    er[8]  = m_lme;
                    er[10] = m_lme & paging_en & pae_en;
                end
            end
            2'd1: begin
                if (!(idx == 0 || idx == 2 || idx == 3 || idx == 4 || (idx == 8 && m64))) ef = 2'd2;
                else if (wr) begin
                    if (m64 && (idx == 0 || idx == 4) && wd[63:32] != 32'd0) ef = 2'd1;
                    if (m64 && idx == 3 && wd[51:40] != 12'd0) ef = 2'd1;
                end else begin
                    er = (idx == 8) ? {60'd0, m_tpr} : m_ctl[idx];
                    if (!m64) er[63:32] = 32'd0;
                end
            end
            2'd2: begin
                if (idx > 7) ef = 2'd2;
                else if (wr) begin
                    if (m64 && (idx == 6 || idx == 7) && wd[63:32] != 32'd0) ef = 2'd1;
                end else begin
                    er = m_dbg[idx];
                    if (!m64) er[63:32] = 32'd0;
                end
            end
            default: ef = 2'd2;
        endcase
        @(posedge clk);
        #1;
        if (wr && ef == 2'd0) begin
            case (sp)
                2'd0: begin m_sce = wd[0]; m_lme = wd[8]; end
                2'd1: if (idx == 8) m_tpr = wd[3:0];
                      else m_ctl[idx] = m64 ? wd : {32'd0, wd[31:0]};
                2'd2: m_dbg[idx] = m64 ? wd : {32'd0, wd[31:0]};
                default: ;
            endcase
        end
        @(negedge clk);
        check({req, " fault"}, {62'd0, fault_code}, {62'd0, ef});
        check({req, " rd_valid"}, {63'd0, rd_valid}, {63'd0, (!wr && ef == 2'd0)});
        if (!wr && ef == 2'd0) check({req, " rdata"}, rd_data, er);
        req_valid = 1'b0;
        @(negedge clk);
        check("R10 fault pulse ends", {61'd0, rd_valid, fault_code}, 64'd0);
    endtask

    task automatic set_env(input bit m, input bit p, input bit a);
        @(negedge clk);
        mode64 = m; paging_en = p; pae_en = a;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin m_ctl[i] = 64'd0; m_dbg[i] = 64'd0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("reset rd_valid", {63'd0, rd_valid}, 64'd0);
        check("reset rdata", rd_data, 64'd0);
        check("reset fault", {62'd0, fault_code}, 64'd0);
        check("R2 reset lma", {63'd0, lma}, 64'd0);
        access(2'd0, 0, 0, 0, "R1 feature reset read");

        // R1 / R2: enable bits, status bit write ignored
        access(2'd0, 0, 1, 64'h501, "R1 R2 feature write with bit 10");
        access(2'd0, 0, 0, 0, "R1 R2 feature readback");
        set_env(1, 1, 0);
        access(2'd0, 0, 0, 0, "R2 paging only");
        set_env(1, 1, 1);
        access(2'd0, 0, 0, 0, "R2 all enables");
        check("R2 lma port", {63'd0, lma}, 64'd1);
        set_env(1, 0, 1);
        access(2'd0, 0, 0, 0, "R2 pae only");
        set_env(1, 1, 1);
        access(2'd0, 0, 1, 64'h0, "R2 clear enable");
        access(2'd0, 0, 0, 0, "R2 cleared read");
        access(2'd0, 0, 1, 64'h100, "R1 set enable");

        // R3: reserved feature bits
        access(2'd0, 0, 1, 64'h103, "R3 reserved bit 1");
        access(2'd0, 0, 1, 64'h8000_0000_0000_0000, "R3 reserved bit 63");
        access(2'd0, 0, 0, 0, "R3 unchanged");

        // R4: CR0/CR4 upper bits
        access(2'd1, 0, 1, 64'h8000_0011, "R4 cr0 ok");
        access(2'd1, 0, 1, 64'h1_0000_0000, "R4 cr0 bit32");
        access(2'd1, 0, 0, 0, "R4 cr0 kept");
        access(2'd1, 4, 1, 64'h0000_06F0, "R4 cr4 ok");
        access(2'd1, 4, 1, 64'h8000_0000_0000_0001, "R4 cr4 bit63");
        access(2'd1, 4, 0, 0, "R4 cr4 kept");

        // R5: CR3 reserved range, CR2 full width
        access(2'd1, 3, 1, 64'hFFF0_00FF_FFFF_F000, "R5 cr3 edges ok");
        access(2'd1, 3, 0, 0, "R5 cr3 read");
        access(2'd1, 3, 1, 64'h0000_0100_0000_0000, "R5 cr3 bit40");
        access(2'd1, 3, 1, 64'h0008_0000_0000_0000, "R5 cr3 bit51");
        access(2'd1, 3, 0, 0, "R5 cr3 kept");
        access(2'd1, 2, 1, 64'hFFFF_8000_1234_5678, "R5 cr2 full");
        access(2'd1, 2, 0, 0, "R5 cr2 read");

        // R6: 32-bit modes
        access(2'd2, 1, 1, 64'hDEAD_BEEF_0000_1111, "R9 dr1 full");
        set_env(0, 1, 1);
        access(2'd1, 2, 0, 0, "R6 cr2 narrow read");
        access(2'd2, 1, 0, 0, "R6 dr1 narrow read");
        access(2'd1, 2, 1, 64'hAAAA_BBBB_CCCC_DDDD, "R6 cr2 narrow write");
        access(2'd1, 0, 1, 64'hFFFF_FFFF_0000_0033, "R6 cr0 no fault narrow");
        access(2'd2, 7, 1, 64'h1234_5678_0000_0400, "R6 dr7 no fault narrow");
        access(2'd0, 0, 0, 0, "R6 feature narrow read");
        set_env(1, 1, 1);
        access(2'd1, 2, 0, 0, "R6 cr2 zero filled");
        access(2'd1, 0, 0, 0, "R6 cr0 zero filled");
        access(2'd2, 7, 0, 0, "R6 dr7 zero filled");

        // R7: task priority register
        access(2'd1, 8, 1, 64'hFFFF_FFFF_FFFF_FFFA, "R7 tpr write");
        access(2'd1, 8, 0, 0, "R7 tpr read");
        set_env(0, 1, 1);
        access(2'd1, 8, 0, 0, "R7 tpr narrow read ud");
        access(2'd1, 8, 1, 64'h3, "R7 tpr narrow write ud");
        set_env(1, 1, 1);
        access(2'd1, 8, 0, 0, "R7 tpr kept");

        // R8: unimplemented indices
        access(2'd1, 1, 0, 0, "R8 cr1");
        access(2'd1, 5, 1, 64'h1, "R8 cr5");
        access(2'd1, 7, 0, 0, "R8 cr7");
        access(2'd1, 9, 1, 64'h5, "R8 cr9");
        access(2'd1, 15, 0, 0, "R8 cr15");
        access(2'd2, 8, 1, 64'h7, "R8 dr8");
        access(2'd2, 15, 0, 0, "R8 dr15");
        access(2'd0, 1, 0, 0, "R8 feature idx1");
        access(2'd3, 0, 1, 64'h1, "R8 space3");
        access(2'd2, 0, 0, 0, "R8 dr0 untouched");

        // R9: debug registers
        access(2'd2, 0, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R9 dr0 full");
        access(2'd2, 3, 1, 64'h0123_4567_89AB_CDEF, "R9 dr3 full");
        access(2'd2, 6, 1, 64'h0000_0100_0000_0000, "R9 dr6 upper");
        access(2'd2, 7, 1, 64'h8000_0000_0000_0000, "R9 dr7 upper");
        access(2'd2, 6, 1, 64'h0000_0000_FFFF_0FF0, "R9 dr6 low ok");
        access(2'd2, 0, 0, 0, "R9 dr0 read");
        access(2'd2, 3, 0, 0, "R9 dr3 read");
        access(2'd2, 6, 0, 0, "R9 dr6 read");
        access(2'd2, 7, 0, 0, "R9 dr7 kept");

        repeat (4) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule